// File: doc/BRIEF.md
# Bit-plane transposer for integer matrices

The block turns a row-major integer matrix, one byte per element, into a stack of binary matrices: plane b holds bit b of every element, laid out row-major, one bit per column. Software supplies the row count, the column count, the precision in use and the source and destination base byte addresses, then pulses `start`. The block reads the source one bus word at a time, spreads each element's low bits into per-bit coalescing registers indexed by column, and writes each register out to its own plane once a bus width of columns has been gathered.

The output is ordered plane-major: all rows of plane 0, then all rows of plane 1, and so on. The words written for one column group therefore sit one plane size (rows*cols/8 bytes) apart. Both memory sides are simple request/response word ports, and only one read or one write is in flight at any time. When the last plane word of the last group has been accepted, `done` rises and stays high until the next `start`.

Top module: `bitplane_xpose`

## Requirements
- R1: Read k of a job (k counted from 0) requests byte address src_base + 8*k. Element e of the returned word sits in bits [8e+7:8e] and is column (8k+e) mod cols of row (8k+e) div cols. A job makes exactly rows*cols/8 reads.
- R2: Only the low P bits of each element affect the output, where P is the latched precision. The upper padding bits of each byte change nothing in the memory image.
- R3: Bit b of the element in column c is placed at bit c mod BUS_W of the plane-b output word. Bit i of an output word is bit i mod 8 of byte i div 8 at that word's address.
- R4: The plane-b word for row r and column group g is written to dst_base + b*(rows*cols/8) + (r*cols + g*BUS_W)/8.
- R5: Each column group of BUS_W columns is flushed as P writes in plane order 0 to P-1. The flush happens after the group's last read returns and before the next group's first read. A job makes (rows*cols/BUS_W)*P writes.
- R6: Plane positions from P up to MAXP-1 are never written. The destination bytes they would occupy keep their prior contents.
- R7: `done` rises only in the cycle after the final write is accepted, and then holds with no request active until the next `start`.
- R8: A request that is not accepted is held, with its address and write data unchanged, until `rd_gnt` or `wr_ack` takes it. `rd_req` and `wr_req` are never high together.
- R9: After reset, `rd_req`, `wr_req`, `busy` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latch the job settings and begin, when idle or finished |
| rows | input | DIM_W | Row count (at least 1) |
| cols | input | DIM_W | Column count, a multiple of BUS_W |
| prec | input | PW | Precision P, from 1 to MAXP; values outside this range are clamped |
| src_base | input | ADDR_W | Source byte address, aligned to BUS_W/8 |
| dst_base | input | ADDR_W | Destination byte address, aligned to BUS_W/8 |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read byte address |
| rd_gnt | input | 1 | Read request accepted |
| rd_valid | input | 1 | Read data valid (at least one cycle after the grant) |
| rd_data | input | BUS_W | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | BUS_W | Write data |
| wr_ack | input | 1 | Write accepted |
| busy | output | 1 | Job in progress |
| done | output | 1 | Job finished |

## Verification
A read address is due in the same cycle as the request, and the data it returns is held in the coalescing registers at the next edge. The first plane write of a group therefore appears one cycle after the group's eighth `rd_valid`. Each later plane write follows one cycle after the previous `wr_ack`, and `done` comes one cycle after the last `wr_ack`. The memory model grants and acknowledges at random, so these latencies vary. For that reason the bench does not count cycles. It checks every accepted transfer at the clock edge where the handshake completes, compares the whole memory image once `done` is seen, and samples the block's outputs on the falling edge.

// File: rtl/bitplane_xpose.sv
module bitplane_xpose #(
  parameter int BUS_W  = 64,
  parameter int MAXP   = 8,
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 12,
  localparam int PW    = $clog2(MAXP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIM_W-1:0]  rows,
  input  logic [DIM_W-1:0]  cols,
  input  logic [PW-1:0]     prec,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_gnt,
  input  logic              rd_valid,
  input  logic [BUS_W-1:0]  rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BUS_W-1:0]  wr_data,
  input  logic              wr_ack,
  output logic              busy,
  output logic              done
);
  localparam int EPW    = BUS_W / 8;
  localparam int EPW_L2 = $clog2(EPW);
  localparam int WPC    = BUS_W / EPW;
  localparam int SW     = $clog2(WPC);
  localparam int IW     = (MAXP > 1) ? $clog2(MAXP) : 1;
  localparam int NW     = 2 * DIM_W;

  typedef enum logic [2:0] {IDLE, RREQ, RWAIT, WRITE, FIN} st_t;
  st_t st;

  logic [PW-1:0]     p_q, plane;
  logic [ADDR_W-1:0] pbytes, words_left, raddr, gaddr, waddr;
  logic [SW-1:0]     wsub;
  logic [MAXP-1:0][BUS_W-1:0] pl;

  logic [NW-1:0] nel;
  logic [PW-1:0] p_eff;
  assign nel   = NW'(rows) * NW'(cols);
  assign p_eff = (prec == '0) ? PW'(1) : (prec > PW'(MAXP)) ? PW'(MAXP) : prec;

  assign rd_req  = (st == RREQ);
  assign rd_addr = raddr;
  assign wr_req  = (st == WRITE);
  assign wr_addr = waddr;
  assign wr_data = pl[plane[IW-1:0]];
  assign busy    = (st != IDLE) && (st != FIN);
  assign done    = (st == FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= IDLE;
      p_q        <= PW'(1);
      plane      <= '0;
      pbytes     <= '0;
      words_left <= '0;
      raddr      <= '0;
      gaddr      <= '0;
      waddr      <= '0;
      wsub       <= '0;
    end else begin
      case (st)
        IDLE, FIN: if (start) begin
          p_q        <= p_eff;
          pbytes     <= ADDR_W'(nel >> 3);
          words_left <= ADDR_W'(nel >> EPW_L2);
          raddr      <= src_base;
          gaddr      <= dst_base;
          wsub       <= '0;
          st         <= (nel == '0) ? FIN : RREQ;
        end
        RREQ: if (rd_gnt) st <= RWAIT;
        RWAIT: if (rd_valid) begin
          raddr      <= raddr + ADDR_W'(EPW);
          wsub       <= wsub + 1'b1;
          words_left <= words_left - 1'b1;
          if (wsub == SW'(WPC - 1)) begin
            plane <= '0;
            waddr <= gaddr;
            st    <= WRITE;
          end else begin
            st <= RREQ;
          end
        end
        WRITE: if (wr_ack) begin
          waddr <= waddr + pbytes;
          plane <= plane + 1'b1;
          if (plane == p_q - 1'b1) begin
            gaddr <= gaddr + ADDR_W'(BUS_W / 8);
            st    <= (words_left == '0) ? FIN : RREQ;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  for (genvar e = 0; e < EPW; e++) begin : g_elem
    for (genvar b = 0; b < MAXP; b++) begin : g_bit
      always_ff @(posedge clk)
        if (st == RWAIT && rd_valid)
          pl[b][{wsub, EPW_L2'(e)}] <= rd_data[8*e + b];
    end
  end
endmodule

// File: rtl/bitplane_xpose_chk.sv
module bitplane_xpose_chk #(
  parameter int BUS_W  = 64,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_gnt,
  input logic              wr_req,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BUS_W-1:0]  wr_data,
  input logic              wr_ack,
  input logic              busy,
  input logic              done
);
  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_gnt |=> rd_req && $stable(rd_addr));

  p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));

  p_quiet_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req && !wr_req && !busy);

  p_done_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wr_req && wr_ack) || $past(start));

  p_done_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);
endmodule

bind bitplane_xpose bitplane_xpose_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk, .rst_n, .start, .rd_req, .rd_addr, .rd_gnt, .wr_req, .wr_addr,
  .wr_data, .wr_ack, .busy, .done
);

// File: tb/sim_bitplane_xpose.sv
module sim_bitplane_xpose;
  localparam int BUS_W = 64, MAXP = 8, ADDR_W = 32, DIM_W = 12, PW = 4;
  localparam int SRC = 32'h100, DST = 32'h4000, MSZ = 1024;

  logic clk = 0, rst_n = 0, start = 0;
  logic [DIM_W-1:0] rows = 0, cols = 0;
  logic [PW-1:0] prec = 0;
  logic rd_req, rd_gnt = 0, rd_valid = 0, wr_req, wr_ack = 0, busy, done;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [BUS_W-1:0] rd_data = '0, wr_data;

  always #4 clk = ~clk;

  bitplane_xpose #(.BUS_W(BUS_W), .MAXP(MAXP), .ADDR_W(ADDR_W), .DIM_W(DIM_W)) u0 (
    .clk, .rst_n, .start, .rows, .cols, .prec,
    .src_base(ADDR_W'(SRC)), .dst_base(ADDR_W'(DST)),
    .rd_req, .rd_addr, .rd_gnt, .rd_valid, .rd_data,
    .wr_req, .wr_addr, .wr_data, .wr_ack, .busy, .done);

  logic [7:0] smem [MSZ];
  logic [7:0] dmem [MSZ];
  int checks = 0, errors = 0;
  int nrd, nwr, rd_err, wr_err, cur_p, cur_pb;
  logic clr = 0, pend = 0;
  int dly = 0;
  logic [ADDR_W-1:0] paddr = '0;

  function automatic logic [BUS_W-1:0] src_word(input logic [ADDR_W-1:0] a);
    logic [BUS_W-1:0] w = '0;
    for (int e = 0; e < 8; e++) w[8*e +: 8] = smem[(int'(a) - SRC + e) % MSZ];
    return w;
  endfunction

  always @(posedge clk) begin
    rd_gnt   <= ($urandom % 4) != 0;
    wr_ack   <= ($urandom % 3) != 0;
    rd_valid <= 1'b0;
    if (clr) begin
      nrd <= 0; nwr <= 0; rd_err <= 0; wr_err <= 0; pend <= 1'b0;
      for (int i = 0; i < MSZ; i++) dmem[i] <= 8'hA5;
    end else begin
      if (rd_req && rd_gnt) begin
        if (rd_addr != ADDR_W'(SRC + 8 * nrd) || nrd / 8 != nwr / cur_p) rd_err <= rd_err + 1;
        nrd <= nrd + 1; pend <= 1'b1; paddr <= rd_addr; dly <= $urandom % 3;
      end
      if (pend) begin
        if (dly == 0) begin rd_valid <= 1'b1; rd_data <= src_word(paddr); pend <= 1'b0; end
        else dly <= dly - 1;
      end
      if (wr_req && wr_ack) begin
        if (wr_addr != ADDR_W'(DST + (nwr % cur_p) * cur_pb + (nwr / cur_p) * 8) ||
            nrd != (nwr / cur_p + 1) * 8) wr_err <= wr_err + 1;
        nwr <= nwr + 1;
        for (int i = 0; i < 8; i++)
          if (int'(wr_addr) - DST + i >= 0 && int'(wr_addr) - DST + i < MSZ)
            dmem[int'(wr_addr) - DST + i] <= wr_data[8*i +: 8];
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int p, input int r, input int c);
    int pb = r * c / 8;
    for (int i = 0; i < r * c; i++) smem[i] = 8'($urandom);
    cur_p = p; cur_pb = pb;
    @(negedge clk); clr = 1; @(negedge clk); clr = 0;
    rows = DIM_W'(r); cols = DIM_W'(c); prec = PW'(p); start = 1;
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
    check("R1 read count", nrd, r * c / 8);
    check("R1 read addresses", rd_err, 0);
    check("R5 write count", nwr, (r * c / BUS_W) * p);
    check("R4 R5 write address and order", wr_err, 0);
    for (int b = 0; b < MAXP; b++)
      for (int k = 0; k < pb; k++) begin
        logic [7:0] exp = 8'hA5;
        if (b < p) for (int j = 0; j < 8; j++) exp[j] = smem[8 * k + j][b];
        check(b < p ? "R3 plane bits (R2 padding ignored)" : "R6 unused plane untouched",
              int'(dmem[b * pb + k]), int'(exp));
      end
    repeat (4) @(negedge clk);
    check("R7 done held", int'(done), 1);
    check("R7 quiet when done", int'(rd_req | wr_req | busy), 0);
  endtask

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    check("R9 reset requests", int'(rd_req | wr_req), 0);
    check("R9 reset flags", int'(busy | done), 0);
    rst_n = 1;
    run_case(1, 1, 64);
    run_case(8, 2, 128);
    run_case(8, 4, 256);
    run_case(1, 4, 256);
    run_case(3, 3, 64);
    for (int t = 0; t < 6; t++)
      run_case(1 + $urandom % 8, 1 + $urandom % 4, 64 * (1 + $urandom % 4));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule